// File: doc/BRIEF.md
# Most-significant-first carry-free signed multiplier

This block multiplies two n-bit two's complement numbers and returns the upper half of the product as a sign bit and an n-bit magnitude. It works serially. It reads the multiplier two bits at a time, starting from the top, as radix-4 digits in the range -2..2. It adds the matching multiple of the multiplicand into a running sum. That sum is kept in carry-save form, so no carry ripples across the word during an iteration.

Each iteration also peels one radix-4 digit of the result off the top of the running sum. The peeled digits are turned into ordinary binary bits as they appear. This is done by two shift registers that always differ by one, so no final adder is needed to assemble the magnitude.

The digits are negated in advance when the operand signs differ, so the accumulated value is always the magnitude of the product. One closing step takes the floor of what is left of the low residual. It needs only the carry-out of the low residual's two rows, not their sum bits.

A user pulses start with both operands present, waits for done, and then reads the sign and the magnitude. These hold until the next accepted start.

Top module: `lrcf_mul`

## Requirements
- R1: A start that is sampled while the block is idle is accepted. Done then goes low, and it rises at exactly the (n/2+1)-th rising clock edge after the accepting edge.
- R2: When done is high, prod_sign is 1 exactly when the true product a_in*b_in (both taken as signed) is negative. It is 0 for zero and for positive products.
- R3: When done is high, prod_mag equals floor(|a_in*b_in| / 2^n), the upper n bits of the 2n-bit magnitude.
- R4: The corner operands give correct results. These are zero, -2^(n-1) and -1 (all ones), including the product (-2^(n-1))*(-2^(n-1)), whose magnitude field is 2^(n-2).
- R5: While done is high and no start is sampled, done, prod_sign and prod_mag keep their values, whatever a_in and b_in do.
- R6: A start sampled while an operation is in progress is ignored. The running operation completes with its own operands and on its own schedule.
- R7: Each iteration's result digit lies in -2..2, and the closing correction digit lies in -3..2. The residual never needs clipping.
- R8: Throughout an operation, the two converter registers hold values that differ by exactly one, modulo 2^n.
- R9: After reset, done, prod_sign and prod_mag are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Accept the operands and begin, when idle |
| a_in | input | N | Multiplicand, two's complement |
| b_in | input | N | Multiplier, two's complement, scanned from the top |
| done | output | 1 | Result valid; held until the next accepted start |
| prod_sign | output | 1 | 1 when the product is negative |
| prod_mag | output | N | Upper n bits of the product magnitude |

## Verification
A wrong internal state cannot be seen while the operation runs. It shows up at the ports only at the done edge, n/2+1 cycles after start, as a wrong prod_mag. The error is often small, because a misselected digit or a broken carry-save row leaves most upper bits correct. For this reason, every operand pair of a small configuration is compared arithmetically, including the pairs whose residual lands just below or just above a multiple of 2^n. A fault in the converter pairing corrupts the low result bits after the first negative digit. A fault in the sign path corrupts prod_sign only for mixed-sign or zero operands, and the sweep covers both cases.

// File: rtl/lrcf_pkg.sv
package lrcf_pkg;
    // signed radix-4 digit, wide enough for -4..3
    typedef logic signed [2:0] digit_t;
    // fractional bits of the digit-selection estimate
    localparam int EST_FRAC  = 5;
    // guard bits of the residual above the n-bit magnitude
    localparam int RES_GUARD = 5;
    // rounding offset used by the selection, in estimate ulps
    localparam int SEL_BIAS  = 17;
endpackage

// File: rtl/lrcf_pp_gen.sv
module lrcf_pp_gen
    import lrcf_pkg::*;
#(
    parameter int N  = 16,
    parameter int RW = N + 5
) (
    input  logic [2:0]    grp,
    input  logic          neg,
    input  logic [N-1:0]  x,
    output logic [RW-1:0] addend,
    output logic          inj
);
    digit_t        raw;
    digit_t        eff;
    logic [RW-1:0] xe;
    logic [RW-1:0] mv;

    always_comb begin
        unique case (grp)
            3'b000:  raw = 3'sd0;
            3'b001:  raw = 3'sd1;
            3'b010:  raw = 3'sd1;
            3'b011:  raw = 3'sd2;
            3'b100:  raw = -3'sd2;
            3'b101:  raw = -3'sd1;
            3'b110:  raw = -3'sd1;
            default: raw = 3'sd0;
        endcase
        eff = neg ? -raw : raw;
        xe  = {{(RW-N){x[N-1]}}, x};
        unique case (eff)
            3'sd2, -3'sd2: mv = xe << 1;
            3'sd1, -3'sd1: mv = xe;
            default:       mv = '0;
        endcase
        if (eff[2]) begin
            addend = ~mv;
            inj    = 1'b1;
        end else begin
            addend = mv;
            inj    = 1'b0;
        end
    end
endmodule

// File: rtl/lrcf_csa.sv
module lrcf_csa #(
    parameter int W = 21
) (
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_b,
    input  logic [W-1:0] in_c,
    output logic [W-1:0] sum,
    output logic [W-1:0] carry
);
    logic [W-1:0] maj;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum[i] = in_a[i] ^ in_b[i] ^ in_c[i];
        assign maj[i] = (in_a[i] & in_b[i]) | (in_a[i] & in_c[i]) | (in_b[i] & in_c[i]);
    end

    assign carry = {maj[W-2:0], 1'b0};
endmodule

// File: rtl/lrcf_digit_sel.sv
module lrcf_digit_sel
    import lrcf_pkg::*;
#(
    parameter int EW = 8
) (
    input  logic [EW-1:0] s_top,
    input  logic [EW-1:0] c_top,
    output digit_t        q,
    output logic          in_range
);
    logic [EW-1:0]      est;
    logic signed [EW:0] t;
    logic signed [EW:0] qr;

    always_comb begin
        est      = s_top + c_top;
        t        = $signed({est[EW-1], est}) + (EW+1)'(SEL_BIAS);
        qr       = t >>> EST_FRAC;
        in_range = (qr >= -(EW+1)'(2)) && (qr <= (EW+1)'(2));
        if (in_range) begin
            q = qr[2:0];
        end else begin
            q = qr[EW] ? -3'sd2 : 3'sd2;
        end
    end
endmodule

// File: rtl/lrcf_otf_step.sv
module lrcf_otf_step
    import lrcf_pkg::*;
#(
    parameter int N = 16
) (
    input  logic [N-1:0] q_in,
    input  logic [N-1:0] qm_in,
    input  digit_t       d,
    output logic [N-1:0] q_out,
    output logic [N-1:0] qm_out
);
    digit_t dm1;
    logic   d_pos;

    always_comb begin
        dm1   = d - 3'sd1;
        d_pos = !d[2] && (d != 3'sd0);
        // appended digit is d mod 4 in both cases; only the prefix is chosen
        q_out  = d[2]  ? {qm_in[N-3:0], d[1:0]}   : {q_in[N-3:0], d[1:0]};
        qm_out = d_pos ? {q_in[N-3:0], dm1[1:0]}  : {qm_in[N-3:0], dm1[1:0]};
    end
endmodule

// File: rtl/lrcf_mul.sv
module lrcf_mul
    import lrcf_pkg::*;
#(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [N-1:0] a_in,
    input  logic [N-1:0] b_in,
    output logic         done,
    output logic         prod_sign,
    output logic [N-1:0] prod_mag
);
    localparam int M     = N / 2;
    localparam int RW    = N + RES_GUARD;
    localparam int EW    = RW - (N - 3);
    localparam int TOPW  = RW - (N + 2);
    localparam int CNT_W = $clog2(M + 1) + 1;

    typedef struct packed {
        logic             busy;
        logic             done;
        logic             neg;
        logic             sgn;
        logic [CNT_W-1:0] cnt;
        logic [N:0]       br;
        logic [N-1:0]     x;
        logic [RW-1:0]    s;
        logic [RW-1:0]    c;
        logic [N-1:0]     q;
        logic [N-1:0]     qm;
    } st_t;

    st_t st_d, st_q;

    logic          last;
    logic [RW-1:0] addend;
    logic          inj;
    logic [RW-1:0] s_sh, c_sh;
    logic [RW-1:0] s_csa, c_csa;
    logic [RW-1:0] s_step;
    digit_t        it_dig;
    logic          sel_ok;
    logic [N:0]    cy;
    logic [RES_GUARD-1:0] fsum;
    digit_t        fdig;
    digit_t        otf_dig;
    logic [N-1:0]  q_nx, qm_nx;

    assign last = (st_q.cnt == CNT_W'(M));

    // multiple of the multiplicand for the current multiplier digit
    lrcf_pp_gen #(.N(N), .RW(RW)) u_pp (
        .grp    (st_q.br[N:N-2]),
        .neg    (st_q.neg),
        .x      (st_q.x),
        .addend (addend),
        .inj    (inj)
    );

    assign s_sh = st_q.s << 2;
    assign c_sh = (st_q.c << 2) | {{(RW-1){1'b0}}, inj};

    lrcf_csa #(.W(RW)) u_csa (
        .in_a  (s_sh),
        .in_b  (c_sh),
        .in_c  (addend),
        .sum   (s_csa),
        .carry (c_csa)
    );

    lrcf_digit_sel #(.EW(EW)) u_sel (
        .s_top    (s_csa[RW-1:N-3]),
        .c_top    (c_csa[RW-1:N-3]),
        .q        (it_dig),
        .in_range (sel_ok)
    );

    // retire the selected digit from the top field of the sum row
    assign s_step = {s_csa[RW-1:N+2] - TOPW'(it_dig), s_csa[N+1:0]};

    // carry-out of the low residual rows: the only chain in the block
    assign cy[0] = 1'b0;
    for (genvar g = 0; g < N; g++) begin : g_cy
        assign cy[g+1] = (st_q.s[g] & st_q.c[g]) | ((st_q.s[g] ^ st_q.c[g]) & cy[g]);
    end

    assign fsum    = st_q.s[RW-1:N] + st_q.c[RW-1:N] + {{(RES_GUARD-1){1'b0}}, cy[N]};
    assign fdig    = fsum[2:0];
    assign otf_dig = last ? fdig : it_dig;

    lrcf_otf_step #(.N(N)) u_otf (
        .q_in   (st_q.q),
        .qm_in  (st_q.qm),
        .d      (otf_dig),
        .q_out  (q_nx),
        .qm_out (qm_nx)
    );

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            st_d.q  = q_nx;
            st_d.qm = qm_nx;
            if (!last) begin
                st_d.s   = s_step;
                st_d.c   = c_csa;
                st_d.br  = {st_q.br[N-2:0], 2'b00};
                st_d.cnt = st_q.cnt + 1'b1;
            end else begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end else if (start) begin
            st_d.busy = 1'b1;
            st_d.done = 1'b0;
            st_d.cnt  = '0;
            st_d.br   = {b_in, 1'b0};
            st_d.x    = a_in;
            st_d.neg  = a_in[N-1] ^ b_in[N-1];
            st_d.sgn  = (a_in[N-1] ^ b_in[N-1]) & (|a_in) & (|b_in);
            st_d.s    = '0;
            st_d.c    = '0;
            st_d.q    = '0;
            st_d.qm   = '1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.qm <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign done      = st_q.done;
    assign prod_sign = st_q.sgn;
    assign prod_mag  = st_q.q;

    // residual stays inside the bound that keeps digits in -2..2
    assert_digit_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !last) |-> sel_ok);

    // closing correction digit stays in -3..2
    assert_final_digit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && last) |-> ($signed(fsum) >= -5'sd3 && $signed(fsum) <= 5'sd2));

    // converter registers stay one apart
    assert_otf_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> (st_q.q == st_q.qm + 1'b1));

    // done rises only after the last iteration
    assert_done_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.done) |-> ($past(st_q.busy) && $past(st_q.cnt) == CNT_W'(M)));

    // result holds while no start arrives
    assert_result_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.done && !start) |=> (done && $stable(prod_mag) && $stable(prod_sign)));
endmodule

// File: tb/tb_lrcf_mul.sv
module tb_lrcf_mul;
    localparam int TN = 6;
    localparam int TM = TN / 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [TN-1:0] a_in = '0;
    logic [TN-1:0] b_in = '0;
    logic          done;
    logic          prod_sign;
    logic [TN-1:0] prod_mag;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    lrcf_mul #(.N(TN)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .a_in      (a_in),
        .b_in      (b_in),
        .done      (done),
        .prod_sign (prod_sign),
        .prod_mag  (prod_mag)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_mag(input int a, input int b);
        int p;
        p = a * b;
        if (p < 0) p = -p;
        return p >> TN;
    endfunction

    function automatic bit is_corner(input int v);
        return (v == 0) || (v == -(1 << (TN-1))) || (v == -1);
    endfunction

    // one operation with latency and result checks
    task automatic run_op(input int a, input int b);
        @(negedge clk);
        start = 1'b1;
        a_in  = TN'(a);
        b_in  = TN'(b);
        @(negedge clk);
        start = 1'b0;
        repeat (TM) @(negedge clk);
        chk("R1 done low before last edge", int'(done), 0);
        @(negedge clk);
        chk("R1 done at n/2+1", int'(done), 1);
        chk("R2 sign", int'(prod_sign), (a * b < 0) ? 1 : 0);
        if (is_corner(a) || is_corner(b))
            chk("R4 corner magnitude", int'(prod_mag), exp_mag(a, b));
        else
            chk("R3 R7 R8 magnitude", int'(prod_mag), exp_mag(a, b));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R9 reset done", int'(done), 0);
        chk("R9 reset sign", int'(prod_sign), 0);
        chk("R9 reset mag", int'(prod_mag), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // full sweep of the small configuration
        for (int a = -(1 << (TN-1)); a < (1 << (TN-1)); a++) begin
            for (int b = -(1 << (TN-1)); b < (1 << (TN-1)); b++) begin
                run_op(a, b);
            end
        end

        // R4: the largest magnitude explicitly
        run_op(-(1 << (TN-1)), -(1 << (TN-1)));
        chk("R4 max magnitude", int'(prod_mag), 1 << (TN-2));

        // R5: hold while operands wiggle without start
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            a_in = TN'(k * 7 + 3);
            b_in = TN'(k * 11 + 5);
            chk("R5 hold done", int'(done), 1);
            chk("R5 hold mag", int'(prod_mag), 1 << (TN-2));
            chk("R5 hold sign", int'(prod_sign), 0);
        end

        // R6: second start during an operation is ignored
        @(negedge clk);
        start = 1'b1;
        a_in  = TN'(-27);
        b_in  = TN'(29);
        @(negedge clk);
        a_in  = TN'(31);
        b_in  = TN'(31);
        @(negedge clk);
        start = 1'b0;
        repeat (TM - 1) @(negedge clk);
        chk("R6 done still low", int'(done), 0);
        @(negedge clk);
        chk("R6 done on schedule", int'(done), 1);
        chk("R6 first operands sign", int'(prod_sign), 1);
        chk("R6 first operands mag", int'(prod_mag), exp_mag(-27, 29));

        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule